// File: doc/BRIEF.md
# PWM Timebase Clock-Enable Generator

This block derives the counting timebase for a bank of eight PWM channels from a single bus clock. It never makes gated clocks. Every rate it produces is a one-bus-cycle enable pulse, and a channel counter in the same clock domain advances on that pulse.

Two base rates, A and B, come from one shared free-running power-of-two prescaler. Each base rate has its own 3-bit exponent select. Each base rate also feeds its own scaled divider, giving rates SA and SB. A scaled divider divides its base rate by twice an 8-bit scale value held inside the block. A scale value is loaded through a value input and a one-cycle write strobe.

The channels are wired in fixed groups. Channels 0, 1, 4 and 5 pick between A and SA. Channels 2, 3, 6 and 7 pick between B and SB. One select bit per channel decides which of the two rates that channel uses.

Top module: `pwm_timebase`

## Requirements
- R1: A synchronous reset (rst high) clears the prescaler count and sets both scale values to 0. Number bus cycles from the first cycle with rst low as cycle 0. With exponent N, the first base pulse then falls in cycle 2^N-1.
- R2: With an exponent of 0, the base pulse is high on every bus cycle.
- R3: With exponent N (0 to 7), base rate A pulses in exactly the cycles c for which c mod 2^N equals 2^N-1. Each pulse is one bus cycle wide.
- R4: Base rate B follows the same rule as base rate A, using its own exponent select, independently of A.
- R5: With scale value S from 1 to 255, SA pulses on the 2S-th, 4S-th, and so on A pulse after its last reload. An SA pulse always coincides with an A pulse.
- R6: A scale value of 0 acts as 256, so the scaled rate pulses once every 512 base pulses. This is also the state after reset.
- R7: A write strobe reloads the divider at once. Counting only the base pulses in cycles after the write cycle, the first scaled pulse falls on the 2S-th of them. A pulse in the write cycle itself follows the old count.
- R8: SB is derived from B by the same rule as R5 to R7, using its own scale value and write strobe.
- R9: Channel bit i of chan_sel picks the rate for channel i: 0 selects the group's base rate and 1 selects its scaled rate. Channels 0, 1, 4 and 5 use A/SA. Channels 2, 3, 6 and 7 use B/SB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| base_sel_a | input | 3 | Exponent N for base rate A (divide by 2^N) |
| base_sel_b | input | 3 | Exponent N for base rate B |
| scale_a_val | input | 8 | Scale value to load for SA |
| scale_a_wr | input | 1 | Write strobe for the SA scale value |
| scale_b_val | input | 8 | Scale value to load for SB |
| scale_b_wr | input | 1 | Write strobe for the SB scale value |
| chan_sel | input | 8 | Per-channel choice: 0 base rate, 1 scaled rate |
| tick_a | output | 1 | Base rate A enable pulse |
| tick_b | output | 1 | Base rate B enable pulse |
| tick_sa | output | 1 | Scaled rate SA enable pulse |
| tick_sb | output | 1 | Scaled rate SB enable pulse |
| chan_tick | output | 8 | Per-channel enable pulses |

## Verification
A corrupted prescaler count shows up as misplaced base pulses. For any exponent above zero, this becomes visible within 2^N bus cycles.

A corrupted divider count or scale value produces no wrong output until the next scaled pulse is due. That can be as late as 512 base pulses, which is 65,536 bus cycles at the slowest base rate. For this reason the bench compares every output on every cycle against an independent cycle-count model. It also runs short scale values, so that divider errors appear within a few hundred cycles.

A wrong channel grouping or wrong select polarity shows up on the first pulse of the affected channel.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

    // Index of each rate group in the base/scaled tick vectors
    localparam int unsigned GRP_A     = 0;
    localparam int unsigned GRP_B     = 1;
    localparam int unsigned GRP_COUNT = 2;

    // Channels are wired in fixed pairs: two on group A, then two on group B, repeating
    function automatic int unsigned chan_group(input int unsigned ch);
        return ((ch % 4) >= 2) ? GRP_B : GRP_A;
    endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter int unsigned SEL_W   = 3,
    parameter int unsigned NUM_SRC = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_SRC-1:0][SEL_W-1:0]   sel,
    output logic [NUM_SRC-1:0]              tick
);
    localparam int unsigned CNT_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } presc_state_t;

    presc_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CNT_W'(1);
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // A divide-by-2^N pulse fires when the low N count bits are all ones
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic [CNT_W-1:0] low_mask;
        assign low_mask = (CNT_W'(1) << sel[g]) - CNT_W'(1);
        assign tick[g]  = &(st_q.cnt | ~low_mask);

        // R3: for any exponent above zero, a pulse is never followed at once by another
        assert_pulse_gap_R3: assert property (@(posedge clk) disable iff (rst)
            (tick[g] && (sel[g] != '0)) |=> (!tick[g] || (sel[g] != $past(sel[g]))));
    end

    // R3: the shared count advances by one on every bus cycle out of reset
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

endmodule

// File: rtl/pwm_scale_div.sv
module pwm_scale_div #(
    parameter int unsigned SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               base_tick,
    input  logic [SCALE_W-1:0] scale_wdata,
    input  logic               scale_we,
    output logic               scaled_tick
);
    localparam int unsigned DIV_W = SCALE_W + 1;

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic [DIV_W-1:0]   rem;
    } div_state_t;

    div_state_t st_d, st_q;

    // Reload value 2*S-1. A zero scale wraps to all ones, which is 2*256-1.
    function automatic logic [DIV_W-1:0] reload_of(input logic [SCALE_W-1:0] s);
        return {s, 1'b0} - DIV_W'(1);
    endfunction

    assign scaled_tick = base_tick && (st_q.rem == '0);

    always_comb begin
        st_d = st_q;
        if (scale_we) begin
            st_d.scale = scale_wdata;
            st_d.rem   = reload_of(scale_wdata);
        end else if (base_tick) begin
            if (st_q.rem == '0) begin
                st_d.rem = reload_of(st_q.scale);
            end else begin
                st_d.rem = st_q.rem - DIV_W'(1);
            end
        end
        if (rst) begin
            st_d.scale = '0;
            st_d.rem   = '1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R5: a scaled pulse only ever lands on a base pulse
    assert_scaled_on_base_R5: assert property (@(posedge clk) disable iff (rst)
        scaled_tick |-> base_tick);

    // R7: after a reload, at least one more base pulse is needed before a scaled pulse
    assert_reload_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        scale_we |=> !scaled_tick);

    // R5: the stored scale value changes only on a write
    assert_scale_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !scale_we |=> $stable(st_q.scale));

endmodule

// File: rtl/pwm_chan_mux.sv
module pwm_chan_mux
    import pwm_timebase_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic [GRP_COUNT-1:0] base_tick,
    input  logic [GRP_COUNT-1:0] scaled_tick,
    input  logic [NUM_CH-1:0]    chan_sel,
    output logic [NUM_CH-1:0]    chan_tick
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        localparam int unsigned GRP = chan_group(ch);
        assign chan_tick[ch] = chan_sel[ch] ? scaled_tick[GRP] : base_tick[GRP];
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_timebase_pkg::*;
#(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned SEL_W   = 3,
    parameter int unsigned SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   base_sel_a,
    input  logic [SEL_W-1:0]   base_sel_b,
    input  logic [SCALE_W-1:0] scale_a_val,
    input  logic               scale_a_wr,
    input  logic [SCALE_W-1:0] scale_b_val,
    input  logic               scale_b_wr,
    input  logic [NUM_CH-1:0]  chan_sel,
    output logic               tick_a,
    output logic               tick_b,
    output logic               tick_sa,
    output logic               tick_sb,
    output logic [NUM_CH-1:0]  chan_tick
);
    logic [GRP_COUNT-1:0][SEL_W-1:0]   grp_sel;
    logic [GRP_COUNT-1:0][SCALE_W-1:0] grp_scale;
    logic [GRP_COUNT-1:0]              grp_we;
    logic [GRP_COUNT-1:0]              base_tick;
    logic [GRP_COUNT-1:0]              scaled_tick;

    assign grp_sel[GRP_A]   = base_sel_a;
    assign grp_sel[GRP_B]   = base_sel_b;
    assign grp_scale[GRP_A] = scale_a_val;
    assign grp_scale[GRP_B] = scale_b_val;
    assign grp_we[GRP_A]    = scale_a_wr;
    assign grp_we[GRP_B]    = scale_b_wr;

    pwm_prescale #(
        .SEL_W   (SEL_W),
        .NUM_SRC (GRP_COUNT)
    ) u_prescale (
        .clk  (clk),
        .rst  (rst),
        .sel  (grp_sel),
        .tick (base_tick)
    );

    for (genvar g = 0; g < GRP_COUNT; g++) begin : g_div
        pwm_scale_div #(
            .SCALE_W (SCALE_W)
        ) u_div (
            .clk         (clk),
            .rst         (rst),
            .base_tick   (base_tick[g]),
            .scale_wdata (grp_scale[g]),
            .scale_we    (grp_we[g]),
            .scaled_tick (scaled_tick[g])
        );
    end

    pwm_chan_mux #(
        .NUM_CH (NUM_CH)
    ) u_mux (
        .base_tick   (base_tick),
        .scaled_tick (scaled_tick),
        .chan_sel    (chan_sel),
        .chan_tick   (chan_tick)
    );

    assign tick_a  = base_tick[GRP_A];
    assign tick_b  = base_tick[GRP_B];
    assign tick_sa = scaled_tick[GRP_A];
    assign tick_sb = scaled_tick[GRP_B];

    // R9: every channel pulse comes from its own group's rates
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        localparam int unsigned GRP = chan_group(ch);
        assert_chan_group_R9: assert property (@(posedge clk) disable iff (rst)
            chan_tick[ch] |-> (base_tick[GRP] || scaled_tick[GRP]));
    end

endmodule

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;

    typedef struct {
        logic [11:0] exp;
        string       tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] base_sel_a = '0;
    logic [2:0] base_sel_b = '0;
    logic [7:0] scale_a_val = '0;
    logic       scale_a_wr = 1'b0;
    logic [7:0] scale_b_val = '0;
    logic       scale_b_wr = 1'b0;
    logic [7:0] chan_sel = '0;
    logic       tick_a, tick_b, tick_sa, tick_sb;
    logic [7:0] chan_tick;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    item_t sb_q[$];

    // Bench model state
    int cyc, acnt_a, acnt_b, scl_a_m, scl_b_m;

    always #2 clk = ~clk;

    pwm_timebase u_dut (
        .clk         (clk),
        .rst         (rst),
        .base_sel_a  (base_sel_a),
        .base_sel_b  (base_sel_b),
        .scale_a_val (scale_a_val),
        .scale_a_wr  (scale_a_wr),
        .scale_b_val (scale_b_val),
        .scale_b_wr  (scale_b_wr),
        .chan_sel    (chan_sel),
        .tick_a      (tick_a),
        .tick_b      (tick_b),
        .tick_sa     (tick_sa),
        .tick_sb     (tick_sb),
        .chan_tick   (chan_tick)
    );

    // Driver: at a falling edge, predict this cycle's outputs, queue them, advance the model
    task automatic step(input string tag);
        item_t it;
        int pa, pb, per_a, per_b;
        bit ea, eb, esa, esb;
        logic [7:0] ech;
        pa    = 1 << base_sel_a;
        pb    = 1 << base_sel_b;
        ea    = (cyc % pa) == pa - 1;
        eb    = (cyc % pb) == pb - 1;
        per_a = 2 * ((scl_a_m == 0) ? 256 : scl_a_m);
        per_b = 2 * ((scl_b_m == 0) ? 256 : scl_b_m);
        esa   = ea && ((acnt_a % per_a) == per_a - 1);
        esb   = eb && ((acnt_b % per_b) == per_b - 1);
        for (int i = 0; i < 8; i++) begin
            if ((i % 4) < 2) ech[i] = chan_sel[i] ? esa : ea;
            else             ech[i] = chan_sel[i] ? esb : eb;
        end
        it.exp = {ech, esb, esa, eb, ea};
        it.tag = tag;
        sb_q.push_back(it);
        cyc++;
        if (scale_a_wr) begin acnt_a = 0; scl_a_m = scale_a_val; end
        else if (ea)    acnt_a++;
        if (scale_b_wr) begin acnt_b = 0; scl_b_m = scale_b_val; end
        else if (eb)    acnt_b++;
        @(negedge clk);
    endtask

    task automatic run(input int n, input string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    task automatic write_a(input logic [7:0] v, input string tag);
        scale_a_val = v;
        scale_a_wr  = 1'b1;
        step(tag);
        scale_a_wr  = 1'b0;
    endtask

    task automatic write_b(input logic [7:0] v, input string tag);
        scale_b_val = v;
        scale_b_wr  = 1'b1;
        step(tag);
        scale_b_wr  = 1'b0;
    endtask

    task automatic do_reset();
        wait (sb_q.size() == 0);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        cyc = 0; acnt_a = 0; acnt_b = 0; scl_a_m = 0; scl_b_m = 0;
        rst = 1'b0;
    endtask

    // Monitor: shortly after each falling edge, compare the outputs to the queued prediction
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [11:0] act;
                it  = sb_q.pop_front();
                act = {chan_tick, tick_sb, tick_sa, tick_b, tick_a};
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d: actual=%b expected=%b", it.tag, cyc, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (R1..all): actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1, R2, R6: exponent 0 pulses every cycle; scale 0 after reset divides by 512
        run(530, "R1/R2/R6");
        // R3, R4: independent exponents on A and B
        base_sel_a = 3'd3;
        base_sel_b = 3'd5;
        run(300, "R3/R4");
        // R5, R8: short scale values on both groups
        base_sel_a = 3'd1;
        base_sel_b = 3'd0;
        write_a(8'd3, "R5");
        write_b(8'd1, "R8");
        run(200, "R5/R8");
        // R7: reload in the middle of a count, including a write on a base pulse
        run(5, "R7");
        write_a(8'd2, "R7");
        run(37, "R7");
        write_b(8'd4, "R7/R8");
        run(100, "R7/R8");
        // R9: channel grouping and select polarity
        chan_sel = 8'b1010_0101;
        run(200, "R9");
        chan_sel = 8'b0101_1010;
        base_sel_b = 3'd2;
        run(200, "R9");
        chan_sel = 8'hFF;
        run(100, "R9");
        // R3: slowest base rates with a short scale
        base_sel_a = 3'd7;
        base_sel_b = 3'd6;
        write_a(8'd1, "R3/R5");
        run(600, "R3/R5");
        // R6: writing zero returns to divide by 512
        base_sel_a = 3'd0;
        write_a(8'd0, "R6");
        run(530, "R6");
        // R1: reset in mid-run restores count and scale values
        base_sel_a = 3'd7;
        base_sel_b = 3'd0;
        chan_sel   = 8'hCC;
        do_reset();
        run(260, "R1");
        base_sel_a = 3'd0;
        run(530, "R1/R6");
        wait (sb_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule